// File: doc/BRIEF.md
# Packed SIMD Variable Left Shifter

This block shifts every element of a 128-bit vector left by its own count. A second 128-bit vector supplies the counts: the element at each index shifts the data element at the same index. A 2-bit format select, set per operation, divides both vectors into sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit lanes. Only the low bits of each count that a lane's width needs are used, so the effective count is the count modulo the lane width. Bits shifted past the top of a lane are dropped, and zeros fill the vacated low bits. No bit ever moves into a neighbouring lane, and no operand value causes a fault.

The block also decodes the 32-bit instruction word that selects this operation. It reports whether the word matches and presents the format and the three register indices the word carries. An output register, present by default, gives one cycle of latency. It loads only on cycles that have an input valid strobe.

Top module: `vshl_top`

## Requirements
- R1: The format select chooses the lane width: 00 gives 8-bit lanes (16 lanes), 01 gives 16-bit (8), 10 gives 32-bit (4), 11 gives 64-bit (2). The result uses the same lane layout.
- R2: Result lane i equals data lane i shifted left by the count held in count lane i, for every lane.
- R3: The effective count is the count modulo the lane width. Only count bits [2:0], [3:0], [4:0] or [5:0] of each count lane are used, for 8, 16, 32 and 64-bit lanes. A count of zero returns the lane unchanged.
- R4: Bits shifted above a lane's top bit are discarded, the vacated low bits are zero, and no bit crosses a lane boundary.
- R5: insn_match is 1 exactly when instruction bits [31:26] equal 011110, bits [25:23] equal 000 and bits [5:0] equal 001101. insn_fmt presents bits [22:21].
- R6: idx_cnt presents instruction bits [20:16], idx_src bits [15:11] and idx_dst bits [10:6], whatever the opcode fields hold.
- R7: With the output register present, out_valid is in_valid delayed by one clock, and res_vec one clock after an in_valid cycle holds the result of that cycle's operands.
- R8: On a clock with in_valid low, res_vec keeps its previous value, whatever the data, count and format inputs do.
- R9: Synchronous active-high reset clears out_valid and res_vec to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| fmt | input | 2 | Lane format select (00 byte, 01 half, 10 word, 11 double) |
| src_vec | input | 128 | Data vector |
| cnt_vec | input | 128 | Per-lane shift counts |
| insn | input | 32 | Instruction word to decode |
| out_valid | output | 1 | Result valid |
| res_vec | output | 128 | Shifted result vector |
| insn_match | output | 1 | Instruction word selects this operation |
| insn_fmt | output | 2 | Format field of the instruction word |
| idx_cnt | output | 5 | Count-register index field |
| idx_src | output | 5 | Source-register index field |
| idx_dst | output | 5 | Destination-register index field |

## Verification
The hardest case to reach from the ports is the modulo reduction: a random count lane seldom holds exactly zero, exactly the lane width minus one, or a value just at or above the width in every lane at once. The bench therefore sweeps every lane's count through 0 to 79 together for each format. This covers zero, width minus one, the width itself and values that wrap, including wrap-around at 64 for doubleword lanes. Random data and random counts follow in each format. All results are compared lane by lane against an arithmetic reference. Each opcode bit is then flipped on its own to show that a single wrong bit stops the match.

// File: rtl/vshl_pkg.sv
package vshl_pkg;

    localparam int VEC_W      = 128;
    localparam int NUM_FMT    = 4;
    localparam int MIN_LANE_W = 8;
    localparam int INSN_W     = 32;

    typedef enum logic [1:0] {
        FMT_BYTE  = 2'b00,
        FMT_HALF  = 2'b01,
        FMT_WORD  = 2'b10,
        FMT_DWORD = 2'b11
    } lane_fmt_e;

    localparam logic [5:0] MAJOR_OPC = 6'b011110;
    localparam logic [2:0] SUB_OPC   = 3'b000;
    localparam logic [5:0] MINOR_OPC = 6'b001101;

    // Field order of the word, most significant first
    typedef struct packed {
        logic [5:0] major;
        logic [2:0] sub;
        logic [1:0] fmt;
        logic [4:0] cnt_idx;
        logic [4:0] src_idx;
        logic [4:0] dst_idx;
        logic [5:0] minor;
    } insn_word_t;

    typedef struct packed {
        logic      match;
        lane_fmt_e fmt;
        logic [4:0] cnt_idx;
        logic [4:0] src_idx;
        logic [4:0] dst_idx;
    } insn_dec_t;

    function automatic int lane_width(input int g);
        return MIN_LANE_W << g;
    endfunction

    function automatic int count_bits(input int g);
        return $clog2(MIN_LANE_W) + g;
    endfunction

endpackage

// File: rtl/vshl_decode.sv
module vshl_decode
    import vshl_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output insn_dec_t         dec
);
    insn_word_t w;
    logic       major_ok, sub_ok, minor_ok;

    always_comb begin
        w        = insn_word_t'(insn);
        major_ok = (w.major == MAJOR_OPC);
        sub_ok   = (w.sub   == SUB_OPC);
        minor_ok = (w.minor == MINOR_OPC);
        dec.match   = major_ok & sub_ok & minor_ok;
        dec.fmt     = lane_fmt_e'(w.fmt);
        dec.cnt_idx = w.cnt_idx;
        dec.src_idx = w.src_idx;
        dec.dst_idx = w.dst_idx;
    end

    // R5
    always_comb begin
        if (insn[31:26] != 6'b011110)
            match_major_chk: assert (!dec.match);
    end
endmodule

// File: rtl/vshl_lanes.sv
module vshl_lanes
    import vshl_pkg::*;
#(
    parameter int W = VEC_W
) (
    input  lane_fmt_e    fmt,
    input  logic [W-1:0] src,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] res
);
    logic [W-1:0] by_fmt [NUM_FMT];
    logic [1:0]   fsel;

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int LW = lane_width(g);
        localparam int CB = count_bits(g);
        localparam int NL = W / LW;
        logic [W-1:0] fmt_res;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] lane_in;
            logic [CB-1:0] lane_sh;
            assign lane_in = src[l*LW +: LW];
            assign lane_sh = cnt[l*LW +: CB];
            assign fmt_res[l*LW +: LW] = lane_in << lane_sh;
        end
        assign by_fmt[g] = fmt_res;
    end

    always_comb begin
        fsel = fmt;
        res  = by_fmt[fsel];
    end

    // R4
    always_comb begin
        if (fmt == FMT_BYTE && cnt[2:0] != 3'd0)
            byte_lsb_zero_chk: assert (res[0] == 1'b0);
    end

    // R3
    always_comb begin
        if (fmt == FMT_DWORD && cnt[5:0] == 6'd0)
            dword_zero_count_chk: assert (res[63:0] == src[63:0]);
    end
endmodule

// File: rtl/vshl_outreg.sv
module vshl_outreg #(
    parameter int W         = 128,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_data  <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) out_data <= in_data;
            end
        end

        // R7
        valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        // R7
        capture_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_data == $past(in_data)));
        // R8
        hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(out_data));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_data  = in_data;
    end
endmodule

// File: rtl/vshl_top.sv
module vshl_top
    import vshl_pkg::*;
#(
    parameter int W       = VEC_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    fmt,
    input  logic [W-1:0]  src_vec,
    input  logic [W-1:0]  cnt_vec,
    input  logic [31:0]   insn,
    output logic          out_valid,
    output logic [W-1:0]  res_vec,
    output logic          insn_match,
    output logic [1:0]    insn_fmt,
    output logic [4:0]    idx_cnt,
    output logic [4:0]    idx_src,
    output logic [4:0]    idx_dst
);
    insn_dec_t    dec;
    logic [W-1:0] shifted;
    lane_fmt_e    fmt_e;

    assign fmt_e = lane_fmt_e'(fmt);

    vshl_decode u_decode (
        .insn (insn),
        .dec  (dec)
    );

    vshl_lanes #(.W(W)) u_lanes (
        .fmt (fmt_e),
        .src (src_vec),
        .cnt (cnt_vec),
        .res (shifted)
    );

    vshl_outreg #(.W(W), .REGISTERED(REG_OUT)) u_outreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (shifted),
        .out_valid (out_valid),
        .out_data  (res_vec)
    );

    assign insn_match = dec.match;
    assign insn_fmt   = dec.fmt;
    assign idx_cnt    = dec.cnt_idx;
    assign idx_src    = dec.src_idx;
    assign idx_dst    = dec.dst_idx;
endmodule

// File: tb/vshl_top_bench.sv
module vshl_top_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   fmt = 2'b00;
    logic [127:0] src_vec = '0;
    logic [127:0] cnt_vec = '0;
    logic [31:0]  insn = '0;
    logic         out_valid;
    logic [127:0] res_vec;
    logic         insn_match;
    logic [1:0]   insn_fmt;
    logic [4:0]   idx_cnt, idx_src, idx_dst;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    vshl_top u_vshl_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt),
        .src_vec(src_vec), .cnt_vec(cnt_vec), .insn(insn),
        .out_valid(out_valid), .res_vec(res_vec), .insn_match(insn_match),
        .insn_fmt(insn_fmt), .idx_cnt(idx_cnt), .idx_src(idx_src), .idx_dst(idx_dst)
    );

    function automatic logic [127:0] ref_shl(input int f, input logic [127:0] a, input logic [127:0] b);
        int w;
        logic [127:0] r;
        logic [63:0] m;
        w = 8 << f;
        r = '0;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int l = 0; l < 128 / w; l++) begin
            logic [63:0] e;
            int sh;
            e  = 64'(a >> (l * w)) & m;
            sh = int'(64'(b >> (l * w)) & 64'd255) % w;
            r  = r | (128'((e << sh) & m) << (l * w));
        end
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input int f, input logic [127:0] a, input logic [127:0] b);
        logic [127:0] exp;
        exp = ref_shl(f, a, b);
        @(negedge clk);
        fmt = 2'(f); src_vec = a; cnt_vec = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R7 valid", 128'(out_valid), 128'd1);
        check(res_vec == exp, "R1 R2 R3 R4 lane result", res_vec, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] good;
        logic [127:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check(out_valid == 1'b0, "R9 valid", 128'(out_valid), 128'd0);
        check(res_vec == '0, "R9 data", res_vec, '0);

        // Sweep: every lane's count forced to the same value 0..79
        for (int f = 0; f < 4; f++) begin
            int w;
            w = 8 << f;
            for (int c = 0; c < 80; c++) begin
                logic [127:0] cv;
                cv = '0;
                for (int l = 0; l < 128 / w; l++) cv = cv | (128'(c) << (l * w));
                run_vec(f, rnd128(), cv);
            end
            for (int k = 0; k < 40; k++) run_vec(f, rnd128(), rnd128());
            // all-ones data exposes lane crossing (R4)
            run_vec(f, '1, rnd128());
        end

        // R8 hold with changing inputs and in_valid low
        held = res_vec;
        @(negedge clk);
        src_vec = rnd128(); cnt_vec = rnd128(); fmt = 2'b10;
        @(negedge clk);
        src_vec = rnd128(); fmt = 2'b01;
        @(negedge clk);
        check(res_vec == held, "R8 hold", res_vec, held);
        check(out_valid == 1'b0, "R7 idle valid", 128'(out_valid), 128'd0);

        // R5 R6 decode
        good = {6'b011110, 3'b000, 2'b10, 5'd19, 5'd7, 5'd28, 6'b001101};
        insn = good; #1;
        check(insn_match == 1'b1, "R5 match", 128'(insn_match), 128'd1);
        check(insn_fmt == 2'b10, "R5 fmt", 128'(insn_fmt), 128'd2);
        check(idx_cnt == 5'd19, "R6 cnt idx", 128'(idx_cnt), 128'd19);
        check(idx_src == 5'd7, "R6 src idx", 128'(idx_src), 128'd7);
        check(idx_dst == 5'd28, "R6 dst idx", 128'(idx_dst), 128'd28);
        for (int b = 0; b < 32; b++) begin
            bit opc_bit;
            opc_bit = (b >= 23) || (b < 6);
            insn = good ^ (32'd1 << b); #1;
            if (opc_bit)
                check(insn_match == 1'b0, "R5 flipped opcode bit", 128'(insn_match), 128'd0);
            else
                check(insn_match == 1'b1, "R5 R6 flipped field bit", 128'(insn_match), 128'd1);
        end
        insn = {6'b000000, 3'b111, 2'b01, 5'd3, 5'd17, 5'd9, 6'b000000}; #1;
        check(insn_match == 1'b0, "R5 no match", 128'(insn_match), 128'd0);
        check({idx_cnt, idx_src, idx_dst} == {5'd3, 5'd17, 5'd9}, "R6 fields on mismatch",
              128'({idx_cnt, idx_src, idx_dst}), 128'({5'd3, 5'd17, 5'd9}));

        // R9 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(res_vec == '0 && out_valid == 1'b0, "R9 re-reset", res_vec, '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule